// File: doc/BRIEF.md
# Cascaded 16-Request Priority Encoder

The block takes sixteen active-low request lines and reports the number of the highest-numbered request that is asserted. It is built from two identical eight-request stages. Each stage works out which of its inputs is the top active one, encodes that position and reports two flags. One flag says the stage saw a request. The other says the stage was enabled but idle, and it is passed on to a lower-priority neighbour. The upper stage covers requests 15..8 and enables the lower stage, which covers requests 7..0, only when none of the upper requests is active.

All inputs and outputs are active low. The logic is purely combinational, with no clock, no registers and no handshake. A caller that needs more than sixteen requests can feed the idle output into the enable of a further, lower-priority copy of the block.

Top module: `prienc_cascade`

## Requirements
- R1: When enabled, the reported index is the highest-numbered active request. Every lower request is ignored, however many are active.
- R2: With only requests 2 and 4 active, the index is 4 and never 6. The same holds for requests 10 and 12, which give 12.
- R3: `valid_n` is low exactly when `en_n` is low and at least one request is low.
- R4: `eo_n` is low exactly when `en_n` is low and no request is low. `eo_n` and `valid_n` are never low together.
- R5: While `en_n` is high, `idx_n`, `valid_n` and `eo_n` are all high, whatever the requests are.
- R6: Any active request in 15..8 wins over every request in 7..0. The top index bit is set exactly when the winner lies in the upper half.
- R7: When enabled with no request active, `idx_n` is all ones.
- R8: Requests are active when 0. The index is driven inverted: `idx_n` equals the bitwise complement of the winning request number, so request k drives `~k` on four bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Active-low enable of the whole encoder |
| req_n | input | 16 | Active-low requests; bit 15 has the highest priority |
| idx_n | output | 4 | Complemented number of the winning request |
| valid_n | output | 1 | Low when some request is being reported |
| eo_n | output | 1 | Low when enabled and idle; enables a lower-priority encoder |

## Verification
The bench aims at the case where a naive design ORs raw request bits instead of winner terms. Requests 2 and 4 together would then read as 6, and the upper-half pair 10 and 12 would read as 14. It drives the boundary between the halves (8 with 7, 15 with 0), where a broken chain from the upper idle flag to the lower enable would merge the two codes. It drives the disabled state with requests held low, which catches a stage that leaks codes or flags while switched off. Every single-request pattern is walked in turn, which exposes any swapped or inverted code bit.

// File: rtl/prienc_pkg.sv
package prienc_pkg;
  localparam int unsigned STAGE_REQS = 8;

  function automatic int unsigned code_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/prienc_winner.sv
// One-hot marker of the highest active input.
module prienc_winner #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] act,
  output logic [N-1:0] win
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_win
      if (i == N - 1) begin : g_top
        assign win[i] = act[i];
      end else begin : g_low
        assign win[i] = act[i] & ~(|act[N-1:i+1]);
      end
    end
  endgenerate
endmodule

// File: rtl/prienc_code.sv
// Encodes a one-hot winner vector into its position.
module prienc_code #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] win,
  output logic [W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      for (int b = 0; b < W; b++) begin
        if (((i >> b) & 1) != 0) code[b] = code[b] | win[i];
      end
    end
  end
endmodule

// File: rtl/prienc_stage.sv
// One active-low encoder stage with chaining flags.
module prienc_stage #(
  parameter int unsigned N = prienc_pkg::STAGE_REQS,
  parameter int unsigned W = prienc_pkg::code_width(N)
) (
  input  logic         en_n,
  input  logic [N-1:0] req_n,
  output logic [W-1:0] code_n,
  output logic         gs_n,
  output logic         eo_n
);
  logic         enabled;
  logic [N-1:0] act;
  logic [N-1:0] win;
  logic [W-1:0] code;
  logic         any;

  assign enabled = ~en_n;
  assign act     = ~req_n & {N{enabled}};
  assign any     = |act;

  prienc_winner #(.N(N)) u_win (.act(act), .win(win));
  prienc_code #(.N(N), .W(W)) u_code (.win(win), .code(code));

  assign code_n = ~code;
  assign gs_n   = ~any;
  assign eo_n   = ~(enabled & ~any);
endmodule

// File: rtl/prienc_cascade.sv
// Two stages chained into one encoder; STAGE_REQS must be a power of two.
module prienc_cascade #(
  parameter int unsigned STAGE_REQS = prienc_pkg::STAGE_REQS,
  parameter int unsigned CW         = prienc_pkg::code_width(STAGE_REQS)
) (
  input  logic                    en_n,
  input  logic [2*STAGE_REQS-1:0] req_n,
  output logic [CW:0]             idx_n,
  output logic                    valid_n,
  output logic                    eo_n
);
  logic [CW-1:0] code_hi_n, code_lo_n;
  logic          gs_hi_n, gs_lo_n, chain_n;

  prienc_stage #(.N(STAGE_REQS), .W(CW)) u_hi (
    .en_n(en_n), .req_n(req_n[2*STAGE_REQS-1:STAGE_REQS]),
    .code_n(code_hi_n), .gs_n(gs_hi_n), .eo_n(chain_n));

  prienc_stage #(.N(STAGE_REQS), .W(CW)) u_lo (
    .en_n(chain_n), .req_n(req_n[STAGE_REQS-1:0]),
    .code_n(code_lo_n), .gs_n(gs_lo_n), .eo_n(eo_n));

  assign idx_n   = {gs_hi_n, code_hi_n & code_lo_n};
  assign valid_n = gs_hi_n & gs_lo_n;
endmodule

// File: rtl/prienc_cascade_chk.sv
module prienc_cascade_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 3
) (
  input logic            en_n,
  input logic [2*N-1:0]  req_n,
  input logic [CW:0]     idx_n,
  input logic            valid_n,
  input logic            eo_n
);
  logic [2*N-1:0] act;
  logic [CW:0]    idx;
  assign act = ~req_n;
  assign idx = ~idx_n;

  always_comb begin
    if (en_n) begin
      p_off_quiet_r5: assert (idx_n == '1 && valid_n && eo_n)
        else $error("disabled encoder drives an output");
    end
    p_flags_exclusive_r4: assert (valid_n || eo_n)
      else $error("valid and idle both active");
    if (!en_n && act == '0) begin
      p_idle_r7: assert (!eo_n && valid_n && idx_n == '1)
        else $error("idle encoder misreports");
    end
    if (!en_n && act != '0) begin
      p_grant_r3: assert (!valid_n && eo_n)
        else $error("request not flagged");
    end
    if (!valid_n) begin
      p_top_winner_r1: assert (act[idx] && ((act >> idx) >> 1) == '0)
        else $error("reported index is not the top request");
    end
  end
endmodule

bind prienc_cascade prienc_cascade_chk #(.N(STAGE_REQS), .CW(CW)) u_chk (
  .en_n(en_n), .req_n(req_n), .idx_n(idx_n), .valid_n(valid_n), .eo_n(eo_n));

// File: tb/tb_prienc_cascade.sv
module tb_prienc_cascade;
  localparam int TOT = 16;

  typedef struct {
    logic [3:0] idx_n;
    logic       valid_n;
    logic       eo_n;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        en_n = 1'b1;
  logic [15:0] req_n = '1;
  logic [3:0]  idx_n;
  logic        valid_n, eo_n;
  int          checks = 0, fails = 0, cycles = 0;
  bit          done = 1'b0;
  exp_t        q[$];

  always #2.5 clk = ~clk;

  prienc_cascade dut (.en_n(en_n), .req_n(req_n), .idx_n(idx_n),
                      .valid_n(valid_n), .eo_n(eo_n));

  function automatic exp_t model(input logic en, input logic [15:0] rq, input string tag);
    exp_t e;
    e.idx_n = '1; e.valid_n = 1'b1; e.eo_n = 1'b1; e.tag = tag;
    if (!en) begin
      e.eo_n = 1'b0;
      for (int i = TOT - 1; i >= 0; i--) begin
        if (!rq[i] && e.valid_n) begin
          e.valid_n = 1'b0; e.eo_n = 1'b1; e.idx_n = ~4'(i);
        end
      end
    end
    return e;
  endfunction

  task automatic apply(input logic en, input logic [15:0] rq, input string tag);
    @(posedge clk);
    en_n  <= en;
    req_n <= rq;
    q.push_back(model(en, rq, tag));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (idx_n !== e.idx_n || valid_n !== e.valid_n || eo_n !== e.eo_n) begin
        fails++;
        $display("FAIL %s: got idx_n=%b valid_n=%b eo_n=%b, expected idx_n=%b valid_n=%b eo_n=%b",
                 e.tag, idx_n, valid_n, eo_n, e.idx_n, e.valid_n, e.eo_n);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    apply(1'b1, 16'hFFFF, "R5 reset state");
    apply(1'b1, 16'h0000, "R5 disabled all requests");
    apply(1'b1, 16'h7FFE, "R5 disabled mixed");
    apply(1'b0, 16'hFFFF, "R7 R4 no request");
    apply(1'b0, ~16'h0014, "R2 requests 2 and 4");
    apply(1'b0, ~16'h1400, "R2 requests 10 and 12");
    apply(1'b0, ~16'h0180, "R6 requests 8 and 7");
    apply(1'b0, ~16'h8001, "R6 requests 15 and 0");
    apply(1'b0, 16'h0000, "R1 all requests");
    apply(1'b0, ~16'h00FF, "R1 lower half full");
    for (int i = 0; i < TOT; i++) apply(1'b0, ~(16'd1 << i), "R8 single request");
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] rq;
      rq = 16'($urandom) | 16'($urandom);
      if (i % 3 == 0) rq = rq | 16'($urandom);
      apply(1'(i % 17 == 0), rq, "R1 R3 R4 R6 random");
    end
    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule